// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block takes 64-bit command writes and turns each one into a single 32-bit store into the register space of another core. The command word carries everything: which core to reach, a four-bit lane-keep mask, part of the target address, and the 32-bit payload in its upper half. A lane whose keep bit is set retains the byte already stored at the target. Every other lane takes the payload byte. When any lane must be kept, the block first reads the target word over its register-bus master port, merges the two words, and then writes the result back. When no lane is kept, the block skips the read and writes the payload whole.

Two command offsets are decoded from the low twelve bits of the write address. The mailbox-send offset aims at one of eight mailbox words of the chosen core, and the slot comes from the command word. The any-send offset aims at any 16-bit register address carried in the command's low half. The target core number travels on a sideband beside each bus request, so the downstream register bank can pick the right core. A core number outside the configured range is answered with an error response, and no bus traffic follows. While a command is in flight the block holds off new ones.

Top module: `mbox_rmw_writer`

## Requirements
- R1: A command acts only when `cmd_wide` is 1 and `cmd_offset` equals the mailbox-send offset (default 0x048) or the any-send offset (default 0x158). Any other command is accepted and then dropped, with no bus request, no response and `busy` left low.
- R2: The target core is `cmd_data[25:16]`. A core number of NUM_CORES or above produces exactly one response with `rsp_err`=1 and no bus request.
- R3: The keep mask is `cmd_data[30:27]`. A set bit 27+i keeps byte i (bits 8i+7:8i) of the old target word, and a clear bit takes byte i of `cmd_data[63:32]`.
- R4: With a nonzero keep mask, the block issues one read of the target word (`bus_we`=0) before the write. The written word is (old AND mask) OR (payload AND NOT mask).
- R5: With a zero keep mask, no read is issued, and the single write carries `cmd_data[63:32]` unchanged.
- R6: A mailbox-send targets address MBOX_BASE + 0x20 + (`cmd_data` AND 0x1C), so bits 4:2 pick one of eight words.
- R7: An any-send targets address `cmd_data[15:0]`.
- R8: `busy` is high from the cycle after an acting command is accepted until the cycle after its one-cycle `rsp_valid` pulse. `cmd_ready` is the inverse of `busy`.
- R9: A command presented while `busy` is high is held off by `cmd_ready`=0. It is executed in order after the current one completes and is never dropped.
- R10: `bus_req` is held, with stable address and direction, until `bus_gnt`. `bus_core` carries the command's core number during every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_wide | input | 1 | Write is a 64-bit access |
| cmd_offset | input | 12 | Low address bits of the command write |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | A command is in flight |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion carried a decode error |
| bus_req | output | 1 | Register-bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Target register address |
| bus_core | output | 10 | Target core number sideband |
| bus_wdata | output | 32 | Write data |
| bus_gnt | input | 1 | Request accepted this cycle |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | 32 | Read data |

## Verification
The bench targets keep masks with single, alternating and full lane patterns. A design with a swapped merge polarity would write the payload into kept lanes, and one that forgot to skip the read would show an extra read before a zero-mask write. It sends core numbers just past the limit and at the field maximum, where a design that compares too few bits would reach a real core and write to it. It stretches the grant latency and queues a command behind a busy one, so that a design that drops held requests, takes a command while busy, or changes the address before the grant gives a missing or wrong transfer. It also uses narrow writes and stray offsets, which a loose decoder would turn into stores.

// File: rtl/mbox_rmw_pkg.sv
package mbox_rmw_pkg;

  localparam int WORD_W   = 32;
  localparam int LANES    = WORD_W / 8;
  localparam int CORE_W   = 10;
  localparam int TADDR_W  = 16;
  localparam int KEEP_LSB = 27;
  localparam int CORE_LSB = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RWAIT = 3'd2,
    ST_WR    = 3'd3,
    ST_DONE  = 3'd4
  } rmw_state_e;

  typedef struct packed {
    logic               hit;
    logic               core_ok;
    logic [CORE_W-1:0]  core;
    logic [LANES-1:0]   keep;
    logic [TADDR_W-1:0] addr;
    logic [WORD_W-1:0]  word;
  } cmd_fields_t;

  // Widen each keep bit to a full byte lane.
  function automatic logic [WORD_W-1:0] keep_lanes(input logic [LANES-1:0] k);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      m[8*i +: 8] = {8{k[i]}};
    end
    return m;
  endfunction

  // Kept lanes come from the old word, the others from the payload.
  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  k);
    logic [WORD_W-1:0] m;
    m = keep_lanes(k);
    return (old_w & m) | (new_w & ~m);
  endfunction

  // Mailbox slot address: base + 0x20 + (command & 0x1C).
  function automatic logic [TADDR_W-1:0] mail_slot_addr(input logic [TADDR_W-1:0] base,
                                                        input logic [2:0]         slot);
    return base + TADDR_W'(16'h0020) + TADDR_W'({slot, 2'b00});
  endfunction

endpackage

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode
  import mbox_rmw_pkg::*;
#(
  parameter int               NUM_CORES = 4,
  parameter int               OFS_W     = 12,
  parameter logic [OFS_W-1:0] MAIL_OFS  = 12'h048,
  parameter logic [OFS_W-1:0] ANY_OFS   = 12'h158,
  parameter logic [15:0]      MBOX_BASE = 16'h1000
) (
  input  logic             cmd_wide,
  input  logic [OFS_W-1:0] cmd_offset,
  input  logic [63:0]      cmd_data,
  output cmd_fields_t      fields
);

  logic is_mail;
  logic is_any;
  logic unused_cmd_bits;

  assign is_mail = cmd_wide && (cmd_offset == MAIL_OFS);
  assign is_any  = cmd_wide && (cmd_offset == ANY_OFS);
  assign unused_cmd_bits = ^{cmd_data[31], cmd_data[26]};

  always_comb begin
    fields.hit     = is_mail || is_any;
    fields.core    = cmd_data[CORE_LSB +: CORE_W];
    fields.core_ok = (32'(fields.core) < 32'(NUM_CORES));
    fields.keep    = cmd_data[KEEP_LSB +: LANES];
    fields.word    = cmd_data[63:32];
    if (is_mail) begin
      fields.addr = mail_slot_addr(MBOX_BASE, cmd_data[4:2]);
    end else begin
      fields.addr = cmd_data[TADDR_W-1:0];
    end
  end

endmodule

// File: rtl/mbox_rmw_ctrl.sv
module mbox_rmw_ctrl
  import mbox_rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic hit,
  input  logic core_ok,
  input  logic keep_nz,
  input  logic bus_gnt,
  input  logic bus_rvalid,
  output logic accept,
  output logic load,
  output logic rd_capture,
  output logic cmd_ready,
  output logic busy,
  output logic bus_req,
  output logic bus_we,
  output logic rsp_valid,
  output logic rsp_err
);

  rmw_state_e state_q, state_d;
  logic       err_q;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign load       = accept && hit && core_ok;
  assign rd_capture = (state_q == ST_RWAIT) && bus_rvalid;
  assign bus_req    = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_we     = (state_q == ST_WR);
  assign rsp_valid  = (state_q == ST_DONE);
  assign rsp_err    = err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && hit) begin
          if (!core_ok)     state_d = ST_DONE;
          else if (keep_nz) state_d = ST_RD;
          else              state_d = ST_WR;
        end
      end
      ST_RD:    if (bus_gnt)    state_d = ST_RWAIT;
      ST_RWAIT: if (bus_rvalid) state_d = ST_WR;
      ST_WR:    if (bus_gnt)    state_d = ST_DONE;
      ST_DONE:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && hit) begin
        err_q <= !core_ok;
      end
    end
  end

endmodule

// File: rtl/mbox_merge_path.sv
module mbox_merge_path
  import mbox_rmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LANES-1:0]   keep_in,
  input  logic [TADDR_W-1:0] addr_in,
  input  logic [CORE_W-1:0]  core_in,
  input  logic [WORD_W-1:0]  word_in,
  input  logic               rd_capture,
  input  logic [WORD_W-1:0]  rdata,
  output logic [TADDR_W-1:0] tgt_addr,
  output logic [CORE_W-1:0]  tgt_core,
  output logic [WORD_W-1:0]  wr_word
);

  logic [LANES-1:0]  keep_q;
  logic [WORD_W-1:0] payload_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q    <= '0;
      payload_q <= '0;
      tgt_addr  <= '0;
      tgt_core  <= '0;
      wr_word   <= '0;
    end else if (load) begin
      keep_q    <= keep_in;
      payload_q <= word_in;
      tgt_addr  <= addr_in;
      tgt_core  <= core_in;
      wr_word   <= word_in;
    end else if (rd_capture) begin
      wr_word   <= merge_word(rdata, payload_q, keep_q);
    end
  end

endmodule

// File: rtl/mbox_rmw_writer.sv
module mbox_rmw_writer
  import mbox_rmw_pkg::*;
#(
  parameter int          NUM_CORES = 4,
  parameter int          OFS_W     = 12,
  parameter logic [11:0] MAIL_OFS  = 12'h048,
  parameter logic [11:0] ANY_OFS   = 12'h158,
  parameter logic [15:0] MBOX_BASE = 16'h1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_wide,
  input  logic [OFS_W-1:0] cmd_offset,
  input  logic [63:0]      cmd_data,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             bus_req,
  output logic             bus_we,
  output logic [15:0]      bus_addr,
  output logic [9:0]       bus_core,
  output logic [31:0]      bus_wdata,
  input  logic             bus_gnt,
  input  logic             bus_rvalid,
  input  logic [31:0]      bus_rdata
);

  cmd_fields_t fld;
  logic        ev_accept;
  logic        ev_load;
  logic        ev_capture;

  mbox_cmd_decode #(
    .NUM_CORES (NUM_CORES),
    .OFS_W     (OFS_W),
    .MAIL_OFS  (MAIL_OFS),
    .ANY_OFS   (ANY_OFS),
    .MBOX_BASE (MBOX_BASE)
  ) dec_i (
    .cmd_wide   (cmd_wide),
    .cmd_offset (cmd_offset),
    .cmd_data   (cmd_data),
    .fields     (fld)
  );

  mbox_rmw_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .hit        (fld.hit),
    .core_ok    (fld.core_ok),
    .keep_nz    (|fld.keep),
    .bus_gnt    (bus_gnt),
    .bus_rvalid (bus_rvalid),
    .accept     (ev_accept),
    .load       (ev_load),
    .rd_capture (ev_capture),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err)
  );

  mbox_merge_path path_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ev_load),
    .keep_in    (fld.keep),
    .addr_in    (fld.addr),
    .core_in    (fld.core),
    .word_in    (fld.word),
    .rd_capture (ev_capture),
    .rdata      (bus_rdata),
    .tgt_addr   (bus_addr),
    .tgt_core   (bus_core),
    .wr_word    (bus_wdata)
  );

endmodule

// File: rtl/mbox_rmw_checker.sv
module mbox_rmw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_accept,
  input logic        ev_hit,
  input logic        ev_core_ok,
  input logic [3:0]  ev_keep,
  input logic        ev_capture,
  input logic        busy,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_gnt,
  input logic [15:0] bus_addr
);

  a_r1_ignored_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !ev_hit |=> !busy);

  a_r2_bad_core_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && ev_hit && !ev_core_ok |=> rsp_valid && rsp_err && !bus_req);

  a_r4_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && ev_hit && ev_core_ok && (ev_keep != 4'd0) |=> bus_req && !bus_we);

  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> bus_req && bus_we);

  a_r5_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && ev_hit && ev_core_ok && (ev_keep == 4'd0) |=> bus_req && bus_we);

  a_r8_rsp_releases: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy && cmd_ready);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_we) && $stable(bus_addr));

endmodule

bind mbox_rmw_writer mbox_rmw_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_accept  (ev_accept),
  .ev_hit     (fld.hit),
  .ev_core_ok (fld.core_ok),
  .ev_keep    (fld.keep),
  .ev_capture (ev_capture),
  .busy       (busy),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_gnt    (bus_gnt),
  .bus_addr   (bus_addr)
);

// File: tb/mbox_rmw_writer_tb_top.sv
`timescale 1ns/1ps
module mbox_rmw_writer_tb_top;

  localparam int          NCORE = 4;
  localparam logic [11:0] OFS_MAIL = 12'h048;
  localparam logic [11:0] OFS_ANY  = 12'h158;
  localparam int          BASE = 32'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_wide = 1'b0;
  logic [11:0] cmd_offset = '0;
  logic [63:0] cmd_data = '0;
  logic        busy, rsp_valid, rsp_err;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [9:0]  bus_core;
  logic [31:0] bus_wdata;
  logic        bus_gnt = 1'b0;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #4 clk = ~clk;

  mbox_rmw_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_wide(cmd_wide), .cmd_offset(cmd_offset), .cmd_data(cmd_data),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_core(bus_core),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata)
  );

  typedef struct {
    bit    we;
    int    core;
    int    addr;
    int    data;
    string tag;
  } op_t;

  op_t op_q[$];
  bit  rsp_q[$];
  int unsigned mem[int];

  int  n_checks = 0;
  int  n_fail = 0;
  int  cycles = 0;
  int  lat = 0;
  int  gcnt = 0;
  bit  rd_pend = 0;
  int  rd_key = 0;
  int  xfers = 0;
  int  rsps = 0;
  bit  mbusy = 0;
  int  last_wait = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int unsigned peek(input int key);
    if (mem.exists(key)) return mem[key];
    return (key * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic bit is_hit(input bit w, input logic [11:0] o);
    return w && (o == OFS_MAIL || o == OFS_ANY);
  endfunction

  function automatic logic [63:0] mk(input int core, input logic [3:0] keep,
                                     input logic [15:0] lo, input logic [31:0] hi);
    logic [63:0] c;
    c = 64'd0;
    c[63:32] = hi;
    c[30:27] = keep;
    c[25:16] = core[9:0];
    c[15:0]  = lo;
    return c;
  endfunction

  // Reference model: expectations built when a command is taken.
  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy <= 0;
    end else if (cmd_valid && cmd_ready && is_hit(cmd_wide, cmd_offset)) begin
      int core, addr, key;
      logic [3:0] keep;
      logic [31:0] hi, old, res;
      string at;
      op_t o;
      mbusy <= 1;
      core = int'(cmd_data[25:16]);
      keep = cmd_data[30:27];
      hi = cmd_data[63:32];
      if (cmd_offset == OFS_MAIL) begin
        addr = BASE + 32'h20 + int'(cmd_data[15:0] & 16'h001C);
        at = "R6";
      end else begin
        addr = int'(cmd_data[15:0]);
        at = "R7";
      end
      if (core >= NCORE) begin
        rsp_q.push_back(1'b1);
      end else begin
        key = core * 65536 + addr;
        old = peek(key);
        if (keep != 4'd0) begin
          o.we = 0; o.core = core; o.addr = addr; o.data = 0;
          o.tag = {"R4 ", at};
          op_q.push_back(o);
          for (int b = 0; b < 4; b++) begin
            res[b*8 +: 8] = keep[b] ? old[b*8 +: 8] : hi[b*8 +: 8];
          end
          o.tag = {"R3 R4 ", at};
        end else begin
          res = hi;
          o.tag = {"R5 ", at};
        end
        o.we = 1; o.core = core; o.addr = addr; o.data = int'(res);
        op_q.push_back(o);
        rsp_q.push_back(1'b0);
      end
    end else if (rsp_valid) begin
      mbusy <= 0;
    end
  end

  // Slave, response and per-clock comparison.
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == mbusy, "R8 busy", busy, mbusy);
      check(cmd_ready == !mbusy, "R8 R9 cmd_ready", cmd_ready, !mbusy);
      if (rsp_valid) begin
        rsps++;
        if (rsp_q.size() == 0) begin
          check(0, "R1 R8 unexpected response", 1, 0);
        end else begin
          bit e;
          e = rsp_q.pop_front();
          check(rsp_err == e, "R2 rsp_err", rsp_err, e);
        end
      end
      if (rd_pend) begin
        bus_rvalid = 1'b1;
        bus_rdata = peek(rd_key);
        rd_pend = 0;
      end else begin
        bus_rvalid = 1'b0;
        bus_rdata = 32'hDEAD_BEEF;
      end
      if (bus_req) begin
        if (gcnt >= lat) begin
          bus_gnt = 1'b1;
          gcnt = 0;
          xfers++;
          if (op_q.size() == 0) begin
            check(0, "R1 R2 unexpected bus transfer", bus_addr, 0);
          end else begin
            op_t o;
            o = op_q.pop_front();
            check(bus_we == o.we, {o.tag, " direction"}, bus_we, o.we);
            check(int'(bus_core) == o.core, {o.tag, " R10 core sideband"}, bus_core, o.core);
            check(int'(bus_addr) == o.addr, {o.tag, " address"}, bus_addr, o.addr);
            if (o.we) begin
              check(bus_wdata == o.data[31:0], {o.tag, " write data"}, bus_wdata, o.data[31:0]);
              mem[o.core * 65536 + o.addr] = o.data;
            end else begin
              rd_key = o.core * 65536 + o.addr;
              rd_pend = 1;
            end
          end
        end else begin
          bus_gnt = 1'b0;
          gcnt++;
        end
      end else begin
        bus_gnt = 1'b0;
        gcnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic send(input bit w, input logic [11:0] o, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wide = w; cmd_offset = o; cmd_data = d;
    last_wait = 0;
    while (!cmd_ready) begin
      @(negedge clk);
      last_wait++;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((op_q.size() != 0 || rsp_q.size() != 0 || busy) && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    check(op_q.size() == 0 && rsp_q.size() == 0, {tag, " all expected work completed"},
          op_q.size() + rsp_q.size(), 0);
  endtask

  initial begin
    int x0, r0;
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check(busy == 0, "R8 reset busy", busy, 0);
    check(bus_req == 0, "R10 reset bus_req", bus_req, 0);
    check(rsp_valid == 0, "R8 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1, "R8 ready after reset", cmd_ready, 1);

    // R5 R6: zero keep mask, mailbox slot 3
    send(1, OFS_MAIL, mk(1, 4'b0000, 16'h000C, 32'hA1B2C3D4)); drain("R5 R6");
    // R3 R4 R6: alternating lanes kept on slot 7
    send(1, OFS_MAIL, mk(2, 4'b0101, 16'h001C, 32'h11223344)); drain("R3 R4");
    // R3 R7: full keep leaves old word, single lane keep
    send(1, OFS_ANY, mk(0, 4'b1111, 16'h1234, 32'hFFFFFFFF)); drain("R3 R7");
    send(1, OFS_ANY, mk(3, 4'b1000, 16'hBEEF, 32'h55667788)); drain("R3 R7");
    // R6: junk low bits outside 4:2 must not move the slot
    send(1, OFS_MAIL, mk(1, 4'b0000, 16'hFFE3, 32'h0BADF00D)); drain("R6");
    // R6 R3: merge into the word written earlier in slot 3
    send(1, OFS_MAIL, mk(1, 4'b0110, 16'h000C, 32'h99887766)); drain("R3 R6");

    // R2: cores just past the limit and at the field maximum
    send(1, OFS_ANY, mk(NCORE, 4'b0000, 16'h0040, 32'h1)); drain("R2");
    send(1, OFS_MAIL, mk(1023, 4'b1010, 16'h0004, 32'h2)); drain("R2");

    // R1: narrow write at a live offset, wide write at stray offsets
    x0 = xfers; r0 = rsps;
    send(0, OFS_MAIL, mk(1, 4'b0000, 16'h0000, 32'h3)); drain("R1");
    send(1, 12'h049, mk(1, 4'b0000, 16'h0000, 32'h4)); drain("R1");
    send(1, 12'h000, mk(2, 4'b0000, 16'h0000, 32'h5)); drain("R1");
    check(xfers == x0, "R1 ignored commands made no transfer", xfers, x0);
    check(rsps == r0, "R1 ignored commands made no response", rsps, r0);
    // R1: the slot the narrow write aimed at still holds its old value
    send(1, OFS_MAIL, mk(1, 4'b1111, 16'h0000, 32'h0)); drain("R1");

    // R9 R10: slow grants and a command queued behind a busy one
    lat = 2;
    send(1, OFS_ANY, mk(2, 4'b0011, 16'h0100, 32'hCAFEBABE));
    send(1, OFS_ANY, mk(2, 4'b1100, 16'h0100, 32'h12345678));
    check(last_wait > 0, "R9 second command held off", last_wait, 1);
    drain("R9");
    send(1, OFS_ANY, mk(2, 4'b0000, 16'h0100, 32'h0));
    send(1, OFS_MAIL, mk(0, 4'b0000, 16'h0008, 32'h77));
    drain("R9 R10");

    // mixed stream
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lat = int'(lf[1:0] % 3);
      send(lf[2] | lf[3], lf[4] ? OFS_MAIL : (lf[5] ? OFS_ANY : 12'h0F0),
           mk(int'(lf[9:7]) & (lf[6] ? 7 : 3), lf[13:10], {8'h01, lf[23:16]},
              lf ^ 32'h6969_0000));
    end
    drain("R4 R5 R9");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule